// File: doc/BRIEF.md
# Password Retry Lockout Counter

This block keeps a running tally of failed password attempts for a secure memory. The password comparator upstream sends it one-cycle pulses. One pulse reports a rejected password of any kind and another reports an accepted one. A third pulse reports a reset-device command that was authenticated with the dedicated reset password. The block drives two outputs. The first is a lock flag, which the access logic uses to refuse every read and write password match. The second is a one-cycle request to wipe all memory arrays.

A run of consecutive failures is tolerated up to a parameterised limit. The failure that fills the counter sets the lock and raises the wipe request once. From then on the counter is frozen, and only an authenticated reset-device command releases the lock. Stored passwords are outside this block, and no path here alters them.

Top module: `pw_retry_guard`

## Requirements
- R1: After reset, `locked` and `wipe_req` are 0 and the failure tally is zero.
- R2: Fewer than `MAX_FAILS` (default 8) failure pulses in a row, with no pass or reset-command pulse between them, raise neither `locked` nor `wipe_req`.
- R3: The failure pulse that brings the tally to `MAX_FAILS` sets `locked` and `wipe_req` on the next clock edge.
- R4: `wipe_req` is high for exactly one cycle for each lockout event.
- R5: A pass pulse while unlocked returns the tally to zero, so a further `MAX_FAILS` failures are needed to lock.
- R6: A reset-command pulse while unlocked returns the tally to zero and raises neither output.
- R7: While `locked` is high, failure pulses are ignored: no further `wipe_req` and the lock stays set.
- R8: While `locked` is high, a pass pulse does not clear the lock.
- R9: A reset-command pulse while locked clears `locked` on the next edge without a `wipe_req`, and counting restarts from zero.
- R10: When pulses coincide in one cycle, reset-command takes precedence over pass, and pass takes precedence over failure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pw_fail | input | 1 | One-cycle pulse: a password was rejected |
| pw_pass | input | 1 | One-cycle pulse: a password was accepted |
| rst_cmd | input | 1 | One-cycle pulse: valid reset-device command |
| locked | output | 1 | High while read and write password matches must be refused |
| wipe_req | output | 1 | One-cycle request to clear all memory arrays |

## Verification
The hardest situation to reach is a long unbroken run of failures. Random stimulus keeps interrupting such runs with pass or reset-command pulses, so a lockout rarely comes from random traffic alone. Directed sequences therefore drive exactly `MAX_FAILS - 1` and `MAX_FAILS` failures, then add failures and passes while locked, then coincident pulses. A biased random phase with rare pass and reset pulses is compared against a bench model. That phase lands in lockout many times and leaves it again.

// File: rtl/pw_retry_guard.sv
module pw_retry_guard #(
  parameter int MAX_FAILS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pw_fail,
  input  logic pw_pass,
  input  logic rst_cmd,
  output logic locked,
  output logic wipe_req
);
  localparam int CW = (MAX_FAILS > 1) ? $clog2(MAX_FAILS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_FAILS - 1);

  logic [CW-1:0] tally;
  logic          hit_limit;

  assign hit_limit = !locked && !rst_cmd && !pw_pass && pw_fail && (tally == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally    <= '0;
      locked   <= 1'b0;
      wipe_req <= 1'b0;
    end else begin
      wipe_req <= hit_limit;
      if (rst_cmd) begin
        tally  <= '0;
        locked <= 1'b0;
      end else if (!locked) begin
        if (pw_pass)
          tally <= '0;
        else if (pw_fail) begin
          if (hit_limit) begin
            tally  <= '0;
            locked <= 1'b1;
          end else
            tally <= tally + 1'b1;
        end
      end
    end
  end
endmodule

module pw_retry_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic pw_fail,
  input logic pw_pass,
  input logic rst_cmd,
  input logic locked,
  input logic wipe_req
);
  p_wipe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_req |=> !wipe_req);
  p_wipe_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_req |-> locked);
  p_lock_needs_wipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> wipe_req);
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rst_cmd) |=> locked);
  p_fail_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && pw_fail && !rst_cmd) |=> !wipe_req);
  p_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rst_cmd) |=> (!locked && !wipe_req));
  p_cmd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd |=> (!wipe_req && !locked));
endmodule

bind pw_retry_guard pw_retry_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pw_fail(pw_fail), .pw_pass(pw_pass),
  .rst_cmd(rst_cmd), .locked(locked), .wipe_req(wipe_req)
);

// File: tb/pw_retry_guard_tb_top.sv
module pw_retry_guard_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pw_fail = 1'b0, pw_pass = 1'b0, rst_cmd = 1'b0;
  logic locked, wipe_req;

  int checks = 0, errors = 0;
  int m_cnt = 0;
  bit m_lock = 1'b0, m_wipe = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pw_retry_guard #(.MAX_FAILS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pw_fail(pw_fail), .pw_pass(pw_pass),
    .rst_cmd(rst_cmd), .locked(locked), .wipe_req(wipe_req)
  );

  function automatic bit next_lock(int c, bit l, bit f, bit p, bit r);
    if (r) return 1'b0;
    if (l) return 1'b1;
    return (!p && f && c == N - 1);
  endfunction

  function automatic int next_cnt(int c, bit l, bit f, bit p, bit r);
    if (r || l || p) return 0;
    if (f) return (c == N - 1) ? 0 : c + 1;
    return c;
  endfunction

  task automatic check(string req, bit exp_l, bit exp_w);
    checks++;
    if (locked !== exp_l || wipe_req !== exp_w) begin
      errors++;
      $display("FAIL %s: locked=%b wipe_req=%b expected locked=%b wipe_req=%b",
               req, locked, wipe_req, exp_l, exp_w);
    end
  endtask

  task automatic step(bit f, bit p, bit r, string req);
    bit nl, nw;
    int nc;
    pw_fail = f; pw_pass = p; rst_cmd = r;
    @(posedge clk);
    #1;
    pw_fail = 1'b0; pw_pass = 1'b0; rst_cmd = 1'b0;
    nw = !r && !m_lock && !p && f && (m_cnt == N - 1);
    nl = next_lock(m_cnt, m_lock, f, p, r);
    nc = next_cnt(m_cnt, m_lock, f, p, r);
    m_lock = nl; m_cnt = nc; m_wipe = nw;
    check(req, m_lock, m_wipe);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    #7;
    check("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    #1;
    check("R1", 1'b0, 1'b0);

    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R2");
    step(0, 1, 0, "R5");
    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R5");
    step(0, 0, 1, "R6");
    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R6");
    step(1, 0, 0, "R3");
    step(0, 0, 0, "R4");
    for (int i = 0; i < N + 2; i++) step(1, 0, 0, "R7");
    step(0, 1, 0, "R8");
    step(1, 1, 0, "R8");
    step(1, 0, 1, "R9");
    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R9");
    step(1, 1, 0, "R10");
    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R10");
    step(1, 1, 1, "R10");
    for (int i = 0; i < N - 1; i++) step(1, 0, 0, "R10");
    step(1, 0, 0, "R3");

    for (int i = 0; i < 4000; i++) begin
      bit f, p, r;
      f = ($urandom % 100) < 70;
      p = ($urandom % 100) < 4;
      r = ($urandom % 100) < (m_lock ? 15 : 2);
      step(f, p, r, "R10");
    end
    summary();
  end
endmodule